// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out store for small words. Both sides use a level handshake on a single clock. A producer raises `shift_in` while `in_rdy` is high, and the word on `din` is taken in. A consumer raises `shift_out` while `out_rdy` is high, and the word shown on `dout` is removed. A word written into an empty store appears on `dout` on its own, with no read request, and `out_rdy` rises to mark it valid.

Each handshake takes exactly one word. The ready flag of a side stays low until its strobe has been released. The read side also holds back the next word until `shift_out` has been low. Because of these two rules, units can be placed in a row to make a deeper store. One unit's `out_rdy` and `dout` feed the next unit's `shift_in` and `din`. The next unit's `in_rdy` returns as the previous unit's `shift_out`.

`mr_n` is an asynchronous, active-low reset. It must be released in step with `clk`. The state at release decides whether a word held on the input is written at once.

Top module: `shift_fifo`

## Requirements
- R1: One unit holds `DEPTH` words (64 by default), counting the word shown on `dout`. While it holds `DEPTH` words `in_rdy` is low and `shift_in` is ignored, so two chained units take exactly 128 words and no more.
- R2: While `mr_n` is low, `dout` is all zeros, `in_rdy` is high and `out_rdy` is low.
- R3: A word is taken at a clock edge where `shift_in` and `in_rdy` are both high. `in_rdy` is low from that edge on and does not rise again before an edge at which `shift_in` is sampled low.
- R4: If `shift_in` is high when `mr_n` is released, the word on `din` is taken at the first clock edge after release. `in_rdy` is low after that edge.
- R5: If `shift_in` is low when `mr_n` is released, `in_rdy` stays high and nothing is stored until `shift_in` is raised.
- R6: Words leave in the order they entered, also across two chained units.
- R7: A word written into an empty, unblocked unit is shown on `dout` with `out_rdy` high at the clock edge after the write edge.
- R8: A word is removed at an edge where `shift_out` and `out_rdy` are both high. `out_rdy` is low after that edge and `dout` is unchanged. `dout` changes only at an edge where `out_rdy` rises, or under reset.
- R9: When the store becomes empty, `dout` keeps the last word removed and `out_rdy` stays low.
- R10: With `shift_out` held high and the store empty since reset, a written word is shown with `out_rdy` high for exactly one cycle. It is then taken, and it stays on `dout`.
- R11: After a word is removed, no further word is shown until `shift_out` has been sampled low. Words written meanwhile wait behind it in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all ports are sampled on its rising edge |
| mr_n | input | 1 | Asynchronous active-low reset |
| shift_in | input | 1 | Write strobe |
| din | input | WIDTH | Word to write |
| in_rdy | output | 1 | Unit can take a word |
| shift_out | input | 1 | Read strobe |
| dout | output | WIDTH | Word at the head of the store |
| out_rdy | output | 1 | `dout` holds a valid word |

## Verification
The bench builds two units with the default `DEPTH` of 64 and `WIDTH` of 4 and chains them into a 128-word store. With the full default depth, the bench can fill the chain completely, which shows that the end-to-end capacity is exactly 128 and that a back-pressured unit recovers when space frees up. The 4-bit width, together with a count that runs past 16, gives repeated data values, so the ordering check against a reference queue also catches a word that is duplicated or dropped. Because the front unit's output flag is a wire visible in the bench, the one-cycle fall-through latency can be measured directly.

// File: rtl/fifo_hs_pkg.sv
package fifo_hs_pkg;

  localparam int DEF_DEPTH = 64;
  localparam int DEF_WIDTH = 4;

  // Read-side sequencing: nothing shown, word shown, waiting for strobe release
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_SHOW = 2'd1,
    RD_HOLD = 2'd2
  } rd_state_e;

endpackage

// File: rtl/shf_store.sv
module shf_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_adv,
  output logic [WIDTH-1:0] head_data,
  output logic [CW-1:0]    occ,
  output logic [CW-1:0]    occ_nxt
);

  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    occ_q;

  // next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) begin
      wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    end
    if (rd_adv) begin
      rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  always_comb begin
    case ({wr_en, rd_adv})
      2'b10:   occ_nxt = occ_q + 1'b1;
      2'b01:   occ_nxt = occ_q - 1'b1;
      default: occ_nxt = occ_q;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_nxt;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  assign head_data = mem[rd_ptr_q];
  assign occ       = occ_q;

endmodule

// File: rtl/shf_wr_ctrl.sv
module shf_wr_ctrl #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_in,
  input  logic [CW-1:0] occ_nxt,
  output logic          wr_en,
  output logic          in_rdy
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic lock_q, lock_d;
  logic rdy_q, rdy_d;

  assign wr_en = shift_in & rdy_q;

  // next-state: a taken word locks the port until the strobe is released
  always_comb begin
    lock_d = lock_q;
    if (wr_en) begin
      lock_d = 1'b1;
    end else if (!shift_in) begin
      lock_d = 1'b0;
    end
    rdy_d = !lock_d && (occ_nxt < FULL_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      lock_q <= lock_d;
      rdy_q  <= rdy_d;
    end
  end

  assign in_rdy = rdy_q;

endmodule

// File: rtl/shf_rd_ctrl.sv
module shf_rd_ctrl
  import fifo_hs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_out,
  input  logic [CW-1:0]    occ,
  input  logic [WIDTH-1:0] head_data,
  output logic             rd_adv,
  output logic             out_rdy,
  output logic [WIDTH-1:0] dout
);

  rd_state_e        state_q, state_d;
  logic [WIDTH-1:0] dout_q;
  logic             load_en;

  assign load_en = (state_q == RD_IDLE) && (occ != '0);
  assign rd_adv  = (state_q == RD_SHOW) && shift_out;

  // next-state
  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE: if (load_en)    state_d = RD_SHOW;
      RD_SHOW: if (shift_out)  state_d = RD_HOLD;
      RD_HOLD: if (!shift_out) state_d = RD_IDLE;
      default:                 state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // output word register with explicit enable; keeps last word when empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (load_en) begin
      dout_q <= head_data;
    end
  end

  assign out_rdy = (state_q == RD_SHOW);
  assign dout    = dout_q;

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import fifo_hs_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy
);

  localparam int CW = $clog2(DEPTH + 1);

  logic             wr_en;
  logic             rd_adv;
  logic [WIDTH-1:0] head_data;
  logic [CW-1:0]    occ;
  logic [CW-1:0]    occ_nxt;

  shf_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (mr_n),
    .wr_en     (wr_en),
    .wr_data   (din),
    .rd_adv    (rd_adv),
    .head_data (head_data),
    .occ       (occ),
    .occ_nxt   (occ_nxt)
  );

  shf_wr_ctrl #(
    .DEPTH (DEPTH)
  ) u_wr (
    .clk      (clk),
    .rst_n    (mr_n),
    .shift_in (shift_in),
    .occ_nxt  (occ_nxt),
    .wr_en    (wr_en),
    .in_rdy   (in_rdy)
  );

  shf_rd_ctrl #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_rd (
    .clk       (clk),
    .rst_n     (mr_n),
    .shift_out (shift_out),
    .occ       (occ),
    .head_data (head_data),
    .rd_adv    (rd_adv),
    .out_rdy   (out_rdy),
    .dout      (dout)
  );

endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             mr_n,
  input logic             shift_in,
  input logic             in_rdy,
  input logic             shift_out,
  input logic             out_rdy,
  input logic [WIDTH-1:0] dout
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW:0] CAP_C = (CW + 1)'(DEPTH);

  // independent occupancy from port handshakes
  logic [CW:0] cnt;
  logic        acc_w, acc_r;

  assign acc_w = shift_in && in_rdy;
  assign acc_r = shift_out && out_rdy;

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      cnt <= '0;
    end else begin
      case ({acc_w, acc_r})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always @(posedge clk) begin
    if (!mr_n) begin
      AST_RESET_VALUES: assert (dout == '0 && in_rdy && !out_rdy) else $error("reset values"); // R2
    end
  end

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!mr_n)
    in_rdy |-> (cnt < CAP_C)) else $error("ready while full"); // R1

  AST_IR_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!mr_n)
    acc_w |=> !in_rdy) else $error("in_rdy after write"); // R3

  AST_OR_NEEDS_WORD: assert property (@(posedge clk) disable iff (!mr_n)
    out_rdy |-> (cnt != '0)) else $error("out_rdy with nothing stored"); // R7

  AST_OR_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!mr_n)
    acc_r |=> !out_rdy) else $error("out_rdy after read"); // R8

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!mr_n)
    !$rose(out_rdy) |-> $stable(dout)) else $error("dout moved without out_rdy rise"); // R8

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!mr_n)
    ($rose(out_rdy) && shift_out) |=> !out_rdy) else $error("pulse longer than one cycle"); // R10

endmodule

bind shift_fifo shift_fifo_chk #(
  .DEPTH (DEPTH),
  .WIDTH (WIDTH)
) i_chk (
  .clk       (clk),
  .mr_n      (mr_n),
  .shift_in  (shift_in),
  .in_rdy    (in_rdy),
  .shift_out (shift_out),
  .out_rdy   (out_rdy),
  .dout      (dout)
);

// File: tb/test_shift_fifo.sv
module test_shift_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NVEC = 12;
  // {word, gap}: gap drives push spacing, gap^5 drives pop spacing
  localparam logic [7:0] VEC [NVEC] = '{
    8'h30, 8'hA2, 8'h51, 8'hF0, 8'h07, 8'h33,
    8'hC1, 8'h34, 8'h90, 8'h62, 8'hE5, 8'h10
  };

  logic clk = 1'b0;
  logic mr_n;
  logic si, so;
  logic [W-1:0] din;
  logic ir0, or01, ir1, or1;
  logic [W-1:0] d01, dout1;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] refq [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  shift_fifo i_shift_fifo (
    .clk (clk), .mr_n (mr_n), .shift_in (si), .din (din), .in_rdy (ir0),
    .shift_out (ir1), .dout (d01), .out_rdy (or01)
  );

  shift_fifo i_shift_fifo_b (
    .clk (clk), .mr_n (mr_n), .shift_in (or01), .din (d01), .in_rdy (ir1),
    .shift_out (so), .dout (dout1), .out_rdy (or1)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] w, input bit lat);
    int t = 0;
    @(negedge clk);
    while (!ir0 && t < 3000) begin @(negedge clk); t++; end
    if (!ir0) begin
      chk("R1 push wait", 8'(ir0), 8'h1);
      return;
    end
    si = 1'b1; din = w;
    @(posedge clk);
    refq.push_back(w);
    @(negedge clk);
    si = 1'b0;
    if (lat) begin
      chk("R3 in_rdy low after write", 8'(ir0), 8'h0);
      chk("R7 not shown at write edge", 8'(or01), 8'h0);
      @(negedge clk);
      chk("R7 shown one edge later", 8'(or01), 8'h1);
      chk("R7 word shown", 8'(d01), 8'(w));
    end
  endtask

  task automatic pop(input bit r8);
    int t = 0;
    logic [W-1:0] got, exp;
    @(negedge clk);
    while (!or1 && t < 3000) begin @(negedge clk); t++; end
    if (!or1) begin
      chk("R6 pop wait", 8'(or1), 8'h1);
      return;
    end
    got = dout1;
    exp = (refq.size() > 0) ? refq.pop_front() : 'x;
    chk("R6 order", 8'(got), 8'(exp));
    so = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (r8) begin
      chk("R8 out_rdy low after read", 8'(or1), 8'h0);
      chk("R8 dout unchanged by read", 8'(dout1), 8'(got));
    end
    so = 1'b0;
  endtask

  task automatic do_reset(input logic si_at_release, input logic [W-1:0] w);
    @(negedge clk);
    mr_n = 1'b0; si = si_at_release; din = w; so = 1'b0;
    refq.delete();
    @(negedge clk);
    mr_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int hi;
    logic [W-1:0] last;
    mr_n = 1'b1; si = 1'b0; so = 1'b0; din = '0;
    #2 mr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 reset dout", 8'(dout1), 8'h0);
    chk("R2 reset in_rdy", 8'(ir0), 8'h1);
    chk("R2 reset out_rdy", 8'(or1), 8'h0);
    mr_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 fall-through latency into an empty front unit
    push(4'h6, 1'b1);
    pop(1'b1);

    // table walk: concurrent producer and consumer, order per R6
    fork
      begin
        for (int i = 0; i < NVEC; i++) begin
          push(VEC[i][7:4], 1'b0);
          repeat (int'(VEC[i][3:0])) @(negedge clk);
        end
      end
      begin
        for (int i = 0; i < NVEC; i++) begin
          repeat (int'(VEC[i][3:0] ^ 4'h5)) @(negedge clk);
          pop(1'b1);
        end
      end
    join

    // R1 fill the 128-word chain, then try to overfill
    for (int i = 0; i < 128; i++) push(4'(i) ^ 4'(i >> 4), 1'b0);
    repeat (20) @(negedge clk);
    chk("R1 in_rdy low when chain full", 8'(ir0), 8'h0);
    si = 1'b1; din = 4'hF;
    repeat (10) @(negedge clk);
    chk("R1 full ignores shift_in", 8'(ir0), 8'h0);
    si = 1'b0;
    for (int i = 0; i < 128; i++) pop(1'b0);
    last = 4'(127) ^ 4'(127 >> 4);
    repeat (20) @(negedge clk);
    chk("R1 no extra word after 128", 8'(or1), 8'h0);
    chk("R9 empty keeps last word", 8'(dout1), 8'(last));
    chk("R9 empty out_rdy low", 8'(or1), 8'h0);

    // R4 release with shift_in high
    @(negedge clk);
    mr_n = 1'b0; si = 1'b1; din = 4'h9; so = 1'b0;
    refq.delete();
    @(negedge clk);
    chk("R2 reset clears held word", 8'(dout1), 8'h0);
    chk("R2 reset out_rdy", 8'(or1), 8'h0);
    mr_n = 1'b1;
    @(negedge clk);
    chk("R4 word taken at first edge", 8'(ir0), 8'h0);
    refq.push_back(4'h9);
    repeat (3) @(negedge clk);
    chk("R3 in_rdy waits for strobe release", 8'(ir0), 8'h0);
    si = 1'b0;
    @(negedge clk);
    chk("R3 in_rdy back after release", 8'(ir0), 8'h1);
    pop(1'b1);

    // R5 release with shift_in low
    do_reset(1'b0, 4'hB);
    repeat (6) @(negedge clk);
    chk("R5 in_rdy high", 8'(ir0), 8'h1);
    chk("R5 nothing written", 8'(or1), 8'h0);
    chk("R5 front unit empty", 8'(or01), 8'h0);
    push(4'h2, 1'b0); push(4'h2, 1'b0); push(4'hD, 1'b0);
    pop(1'b0); pop(1'b0); pop(1'b0);

    // R10 / R11 shift_out held high on an empty chain
    do_reset(1'b0, 4'h0);
    so = 1'b1;
    push(4'hA, 1'b0);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (or1) hi++; end
    chk("R10 out_rdy pulse width", 8'(hi), 8'h1);
    chk("R10 word kept on dout", 8'(dout1), 8'hA);
    void'(refq.pop_front());
    push(4'h4, 1'b0); push(4'h7, 1'b0);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (or1) hi++; end
    chk("R11 queued words not shown", 8'(hi), 8'h0);
    chk("R11 dout still first word", 8'(dout1), 8'hA);
    so = 1'b0;
    pop(1'b1);
    pop(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule